// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a register of `WIDTH` bits (eight by default) that changes state only on the rising clock edge. Each edge it performs one of five operations: it keeps its contents, shifts one place toward the higher bit index, shifts one place toward the lower bit index, takes a parallel word from the bus, or clears itself. The active-low synchronous clear takes precedence over the two mode-select inputs.

One parallel bus serves both directions. It is modelled as a separate input word, an output word and a single output-enable. The output word always carries the register contents. The enable is combinational. It drops when either of two active-low enable inputs is high, and it also drops whenever load mode is selected, so that an outside driver can own the bus during a load. Switching the drivers off never stops the register from working.

Each end bit has its own serial input. Each end bit is also copied to a dedicated serial output that the enables do not gate. This lets several registers be chained into a longer word: the top serial output of one stage feeds the bottom serial input of the next, and the reverse path carries data the other way.

Top module: `usr_shift_bus`

## Requirements
- R1: With `mode_sel` = 2'b00 and `clr_n` high, a rising edge leaves every bit unchanged.
- R2: With `mode_sel` = 2'b01 and `clr_n` high, a rising edge moves each bit n to bit n+1 and loads `ser_in_lo` into bit 0.
- R3: With `mode_sel` = 2'b10 and `clr_n` high, a rising edge moves each bit n to bit n-1 and loads `ser_in_hi` into bit WIDTH-1.
- R4: With `mode_sel` = 2'b11 and `clr_n` high, a rising edge writes the value of `bus_in` into all bits.
- R5: With `clr_n` low, the next rising edge clears every bit, whatever the value of `mode_sel`.
- R6: `bus_oe` is high exactly when `oe_a_n` and `oe_b_n` are both low and `mode_sel` is not 2'b11. It follows its inputs without a clock edge.
- R7: When `bus_oe` is low, clear, load, shift and hold act exactly as in R1 to R5, and `bus_out` keeps showing the register contents.
- R8: `ser_out_lo` always equals bit 0 and `ser_out_hi` always equals bit WIDTH-1, whatever the enable inputs are.
- R9: Two instances chained through their serial pins behave as a single 2*WIDTH-bit register when shifted in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Active-low synchronous clear, overrides the mode |
| mode_sel | input | 2 | Operation: 00 hold, 01 shift up, 10 shift down, 11 load |
| oe_a_n | input | 1 | Active-low bus enable, first of two |
| oe_b_n | input | 1 | Active-low bus enable, second of two |
| ser_in_lo | input | 1 | Serial data that enters bit 0 on a shift up |
| ser_in_hi | input | 1 | Serial data that enters the top bit on a shift down |
| bus_in | input | WIDTH | Parallel word sampled during a load |
| bus_out | output | WIDTH | Register contents for the shared bus |
| bus_oe | output | 1 | High when the bus drivers are on |
| ser_out_lo | output | 1 | Copy of bit 0 for chaining |
| ser_out_hi | output | 1 | Copy of the top bit for chaining |

## Verification
The bench builds two instances at the default WIDTH of 8 and chains them into one 16-bit word. This exercises the hand-off of bits between stages in both shift directions, a path that a single instance cannot show. With only two mode bits and two enable bits, random stimulus covers every combination of mode and enable many times. Directed sequences walk a single one across all sixteen positions and force a clear while load is selected.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_UP   = 2'b01,
        OP_DOWN = 2'b10,
        OP_LOAD = 2'b11
    } usr_op_e;

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    output usr_op_e    op,
    output logic       bus_oe
);

    logic enables_low;

    always_comb begin
        op          = usr_op_e'(mode_sel);
        enables_low = ~oe_a_n & ~oe_b_n;
        // drivers release the bus for an external source during load
        bus_oe      = enables_low & (op != OP_LOAD);
    end

endmodule

// File: rtl/usr_shift_next.sv
module usr_shift_next
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  usr_op_e          op,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] bus_in,
    input  logic             ser_in_lo,
    input  logic             ser_in_hi,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_below;
        logic from_above;
        logic bit_d;

        if (i == 0) begin : g_lo_end
            assign from_below = ser_in_lo;
        end else begin : g_lo_mid
            assign from_below = cur[i-1];
        end

        if (i == TOP) begin : g_hi_end
            assign from_above = ser_in_hi;
        end else begin : g_hi_mid
            assign from_above = cur[i+1];
        end

        always_comb begin
            if (!clr_n) begin
                bit_d = 1'b0;
            end else begin
                unique case (op)
                    OP_UP:   bit_d = from_below;
                    OP_DOWN: bit_d = from_above;
                    OP_LOAD: bit_d = bus_in[i];
                    default: bit_d = cur[i];
                endcase
            end
        end

        assign nxt[i] = bit_d;
    end

endmodule

// File: rtl/usr_shift_bus.sv
module usr_shift_bus
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode_sel,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             ser_in_lo,
    input  logic             ser_in_hi,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             ser_out_lo,
    output logic             ser_out_hi
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } usr_state_t;

    usr_state_t       st_d;
    usr_state_t       st_q;
    usr_op_e          op;
    logic [WIDTH-1:0] nxt;

    usr_mode_decode u_decode (
        .mode_sel (mode_sel),
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .op       (op),
        .bus_oe   (bus_oe)
    );

    usr_shift_next #(
        .WIDTH (WIDTH)
    ) u_next (
        .op        (op),
        .clr_n     (clr_n),
        .cur       (st_q.data),
        .bus_in    (bus_in),
        .ser_in_lo (ser_in_lo),
        .ser_in_hi (ser_in_hi),
        .nxt       (nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.data = nxt;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bus_out    = st_q.data;
    assign ser_out_lo = st_q.data[0];
    assign ser_out_hi = st_q.data[TOP];

endmodule

// File: rtl/usr_shift_bus_chk.sv
module usr_shift_bus_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       mode_sel,
    input logic             oe_a_n,
    input logic             oe_b_n,
    input logic             ser_in_lo,
    input logic             ser_in_hi,
    input logic [WIDTH-1:0] bus_in,
    input logic [WIDTH-1:0] bus_out,
    input logic             bus_oe,
    input logic             ser_out_lo,
    input logic             ser_out_hi
);

    logic armed_q = 1'b0;

    always_ff @(posedge clk) begin
        if (!clr_n) armed_q <= 1'b1;
    end

    // R1 and R7: hold keeps contents, whatever the bus enable
    assert_hold_R1: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && mode_sel == 2'b00) |=> $stable(bus_out));

    // R2
    assert_shift_up_R2: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && mode_sel == 2'b01) |=>
        bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_in_lo)});

    // R3
    assert_shift_down_R3: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && mode_sel == 2'b10) |=>
        bus_out == {$past(ser_in_hi), $past(bus_out[WIDTH-1:1])});

    // R4
    assert_load_R4: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && mode_sel == 2'b11) |=> bus_out == $past(bus_in));

    // R5
    assert_clear_R5: assert property (@(posedge clk) disable iff (!armed_q)
        !clr_n |=> bus_out == '0);

    // R6
    assert_bus_enable_R6: assert property (@(posedge clk) disable iff (!armed_q)
        bus_oe == (!oe_a_n && !oe_b_n && mode_sel != 2'b11));

    // R8
    assert_serial_taps_R8: assert property (@(posedge clk) disable iff (!armed_q)
        ser_out_lo == bus_out[0] && ser_out_hi == bus_out[WIDTH-1]);

endmodule

bind usr_shift_bus usr_shift_bus_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .clr_n      (clr_n),
    .mode_sel   (mode_sel),
    .oe_a_n     (oe_a_n),
    .oe_b_n     (oe_b_n),
    .ser_in_lo  (ser_in_lo),
    .ser_in_hi  (ser_in_hi),
    .bus_in     (bus_in),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .ser_out_lo (ser_out_lo),
    .ser_out_hi (ser_out_hi)
);

// File: tb/usr_shift_bus_bench.sv
module usr_shift_bus_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int W2         = 2 * W;
    localparam int N_RANDOM   = 3000;

    logic          clk = 1'b0;
    logic          clr_n;
    logic [1:0]    mode_sel;
    logic          oe_a_n, oe_b_n;
    logic          ext_lo, ext_hi;
    logic [W-1:0]  bus_in_lo, bus_in_hi;
    logic [W-1:0]  bus_out_lo, bus_out_hi;
    logic          oe_lo, oe_hi;
    logic          a_sol, a_soh, b_sol, b_soh;

    int checks   = 0;
    int failures = 0;
    logic [W2-1:0] model;

    always #(CLK_PERIOD/2) clk = ~clk;

    // low stage: bits 0..7
    usr_shift_bus #(.WIDTH(W)) u_usr_shift_bus (
        .clk (clk), .clr_n (clr_n), .mode_sel (mode_sel),
        .oe_a_n (oe_a_n), .oe_b_n (oe_b_n),
        .ser_in_lo (ext_lo), .ser_in_hi (b_sol),
        .bus_in (bus_in_lo), .bus_out (bus_out_lo), .bus_oe (oe_lo),
        .ser_out_lo (a_sol), .ser_out_hi (a_soh)
    );

    // high stage: bits 8..15
    usr_shift_bus #(.WIDTH(W)) u_usr_shift_bus_hi (
        .clk (clk), .clr_n (clr_n), .mode_sel (mode_sel),
        .oe_a_n (oe_a_n), .oe_b_n (oe_b_n),
        .ser_in_lo (a_soh), .ser_in_hi (ext_hi),
        .bus_in (bus_in_hi), .bus_out (bus_out_hi), .bus_oe (oe_hi),
        .ser_out_lo (b_sol), .ser_out_hi (b_soh)
    );

    function automatic logic [W2-1:0] ref_next(input logic [W2-1:0] cur,
        input logic clr, input logic [1:0] m, input logic lo, input logic hi,
        input logic [W2-1:0] par);
        if (!clr) return '0;
        case (m)
            2'b01:   return {cur[W2-2:0], lo};
            2'b10:   return {hi, cur[W2-1:1]};
            2'b11:   return par;
            default: return cur;
        endcase
    endfunction

    function automatic logic ref_oe(input logic a, input logic b, input logic [1:0] m);
        return !a && !b && (m != 2'b11);
    endfunction

    function automatic string req_of(input logic clr, input logic [1:0] m);
        if (!clr) return "R5";
        case (m)
            2'b01:   return "R2";
            2'b10:   return "R3";
            2'b11:   return "R4";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // drive at negedge, check enables, clock, then check state
    task automatic step(input logic clr, input logic [1:0] m, input logic a,
        input logic b, input logic lo, input logic hi, input logic [W2-1:0] par);
        string tag;
        @(negedge clk);
        clr_n = clr; mode_sel = m; oe_a_n = a; oe_b_n = b;
        ext_lo = lo; ext_hi = hi; {bus_in_hi, bus_in_lo} = par;
        #1;
        check("R6", {62'd0, oe_hi, oe_lo}, {62'd0, {2{ref_oe(a, b, m)}}});
        model = ref_next(model, clr, m, lo, hi, par);
        @(posedge clk);
        #1;
        tag = req_of(clr, m);
        if (!(ref_oe(a, b, m))) tag = {tag, "/R7"};
        check({tag, "/R9"}, {48'd0, bus_out_hi, bus_out_lo}, {48'd0, model});
        check("R8", {60'd0, b_soh, b_sol, a_soh, a_sol},
              {60'd0, model[W2-1], model[W], model[W-1], model[0]});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model = '0;
        clr_n = 1'b0; mode_sel = 2'b00; oe_a_n = 1'b0; oe_b_n = 1'b0;
        ext_lo = 1'b0; ext_hi = 1'b0; bus_in_lo = '0; bus_in_hi = '0;

        // reset state, R5 with load selected
        step(1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF);
        check("R5", {48'd0, bus_out_hi, bus_out_lo}, 64'd0);

        // R4 load under disabled drivers (R7)
        step(1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 16'hA55A);
        check("R4", {48'd0, bus_out_hi, bus_out_lo}, 64'h0000_0000_0000_A55A);
        // R1 hold with enables off, R7
        step(1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1234);
        check("R1", {48'd0, bus_out_hi, bus_out_lo}, 64'h0000_0000_0000_A55A);
        // R5 clear while shift selected
        step(1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFF);
        check("R5", {48'd0, bus_out_hi, bus_out_lo}, 64'd0);

        // R9 walk a single one up through all sixteen bits and out
        step(1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        for (int k = 1; k < W2; k++) step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        check("R9", {48'd0, bus_out_hi, bus_out_lo}, 64'h0000_0000_0000_8000);
        step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        check("R9", {48'd0, bus_out_hi, bus_out_lo}, 64'd0);

        // R9 walk a one down from the top
        step(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
        for (int k = 1; k < W2; k++) step(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        check("R9", {48'd0, bus_out_hi, bus_out_lo}, 64'h0000_0000_0000_0001);

        // every mode and enable combination for R6
        for (int c = 0; c < 16; c++)
            step(1'b1, c[1:0], c[2], c[3], 1'b1, 1'b0, 16'hC3C3);

        // constrained random mix
        for (int n = 0; n < N_RANDOM; n++) begin
            logic r_clr;
            r_clr = ($urandom % 32) != 0;
            step(r_clr, 2'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
                 1'($urandom), 1'($urandom), 16'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule